// File: doc/BRIEF.md
# Video Frame Timing Region Sequencer

The sequencer walks a programmed video raster one pixel clock at a time and reports where in the frame it is. Software programs the horizontal sync width, the horizontal back-porch width, the active pixel count and the total line length in pixel clocks. It also programs the vertical sync, back-porch, active and front-porch line counts. From these the block produces hsync, vsync and data-enable strobes. Each strobe has its own polarity select, and a further bit chooses the pixel-data qualifying edge. The block also outputs a pixel and line counter pair, a vertical region code, a horizontal sub-code and a one-cycle frame-start pulse.

Each blanking region has its own enable bit that marks whether the serial link may drop to low power there. The block combines these bits into one low-power-allowed flag, and a second flag also requires the enable for low-power commands. The sequencer runs only while it is enabled, set to video mode and set to burst transmission. It captures its configuration only at the start of a frame. The horizontal front porch is not programmed directly. It is whatever remains of the line after sync, back porch and active pixels, and a configuration with no room for it is flagged as an error.

Top module: `vid_region_seq`

## Requirements
- R1: The sequencer runs only while `en`, `cfg_video_mode` (1 = video) and `cfg_burst` (1 = burst) are all 1. Otherwise it is idle: `hcnt` and `vcnt` are 0, `frame_start`, `lp_ok`, `lp_cmd_ok` and `cfg_err` are 0, and each strobe sits at its inactive level.
- R2: While running, `hcnt` counts 0 to `hline`-1 and then wraps to 0. `vcnt` advances by one at each wrap and returns to 0 after `vsa`+`vbp`+`vact`+`vfp` lines.
- R3: `vregion` is 0 for lines below `vsa` (sync), 1 for the next `vbp` lines (back porch), 2 for the next `vact` lines (active) and 3 for the remaining lines (front porch).
- R4: `hregion` is 0 for pixels below `hsa`, 1 for the next `hbp` pixels, 2 for the next `hact` pixels and 3 for the rest of the line. The front porch is `hline`-`hsa`-`hbp`-`hact` pixels long.
- R5: hsync is asserted on every line while `hregion` is 0. vsync is asserted while `vregion` is 0. Data-enable is asserted only when `vregion` is 2 and `hregion` is 2.
- R6: Each of `hsync`, `vsync` and `de` has its own select bit (`pol_hs_low`, `pol_vs_low`, `pol_de_low`), where 1 means the strobe is driven low when asserted and high otherwise. `pix_fall` outputs `pol_pix_fall` as captured for the current frame.
- R7: `lp_ok` follows `lp_vsa_en` in region 0, `lp_vbp_en` in region 1 and `lp_vfp_en` in region 3. In region 2 it follows `lp_hfp_en` in horizontal sub-code 3 and `lp_vact_en` in sub-codes 0 and 1, and it is 0 during active pixels.
- R8: `lp_cmd_ok` is 1 exactly when `lp_ok` is 1 and `lp_cmd_en` is 1.
- R9: `frame_start` is 1 for exactly the cycles where a running, error-free sequencer has `hcnt` = 0 and `vcnt` = 0, which is the first pixel of the sync region.
- R10: Configuration and polarity inputs are captured when a frame starts. A change made during a frame takes effect from the next frame.
- R11: `cfg_err` is 1 when the captured configuration has `hline` <= `hsa`+`hbp`+`hact` or a vertical total of zero. While it is 1, the counters stay at 0, the outputs are idle and the inputs are captured again every cycle. A corrected configuration starts a frame on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sequencer enable |
| cfg_video_mode | input | 1 | 1 = video mode, 0 = command mode |
| cfg_burst | input | 1 | 1 = burst transmission type |
| hsa | input | HW | Horizontal sync width in pixels |
| hbp | input | HW | Horizontal back-porch width in pixels |
| hact | input | HW | Active pixels per line |
| hline | input | HW | Total line length in pixels |
| vsa | input | VW | Vertical sync lines |
| vbp | input | VW | Vertical back-porch lines |
| vact | input | VW | Active lines |
| vfp | input | VW | Vertical front-porch lines |
| pol_hs_low | input | 1 | hsync active low |
| pol_vs_low | input | 1 | vsync active low |
| pol_de_low | input | 1 | Data-enable active low |
| pol_pix_fall | input | 1 | Pixel data qualified on falling edge |
| lp_vsa_en | input | 1 | Low power allowed in vertical sync |
| lp_vbp_en | input | 1 | Low power allowed in vertical back porch |
| lp_vact_en | input | 1 | Low power allowed in blanking of active lines |
| lp_vfp_en | input | 1 | Low power allowed in vertical front porch |
| lp_hfp_en | input | 1 | Low power allowed in horizontal front porch |
| lp_cmd_en | input | 1 | Commands may be sent in low power |
| hsync | output | 1 | Horizontal sync strobe |
| vsync | output | 1 | Vertical sync strobe |
| de | output | 1 | Data-enable strobe |
| pix_fall | output | 1 | Captured pixel edge select |
| hcnt | output | HW | Pixel position in line |
| vcnt | output | VW+2 | Line position in frame |
| vregion | output | 2 | Vertical region code |
| hregion | output | 2 | Horizontal sub-code |
| lp_ok | output | 1 | Low power allowed now |
| lp_cmd_ok | output | 1 | Low-power command allowed now |
| frame_start | output | 1 | First pixel of frame |
| cfg_err | output | 1 | Captured configuration invalid |

## Verification
The bench builds the block with HW = 8 and VW = 6, so frames of a few dozen to about a hundred pixel clocks are covered in full, one pixel at a time. At that size it can run all 64 combinations of the six low-power enables and sixteen polarity patterns through whole frames. It also covers degenerate rasters with zero-length sync and porch regions, a mid-frame reprogramming across a frame boundary, and each way a configuration can leave no front porch or no lines.

// File: rtl/vid_region_seq.sv
module vid_region_seq #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cfg_video_mode,
  input  logic          cfg_burst,
  input  logic [HW-1:0] hsa,
  input  logic [HW-1:0] hbp,
  input  logic [HW-1:0] hact,
  input  logic [HW-1:0] hline,
  input  logic [VW-1:0] vsa,
  input  logic [VW-1:0] vbp,
  input  logic [VW-1:0] vact,
  input  logic [VW-1:0] vfp,
  input  logic          pol_hs_low,
  input  logic          pol_vs_low,
  input  logic          pol_de_low,
  input  logic          pol_pix_fall,
  input  logic          lp_vsa_en,
  input  logic          lp_vbp_en,
  input  logic          lp_vact_en,
  input  logic          lp_vfp_en,
  input  logic          lp_hfp_en,
  input  logic          lp_cmd_en,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_fall,
  output logic [HW-1:0] hcnt,
  output logic [VW+1:0] vcnt,
  output logic [1:0]    vregion,
  output logic [1:0]    hregion,
  output logic          lp_ok,
  output logic          lp_cmd_ok,
  output logic          frame_start,
  output logic          cfg_err
);
  localparam int HS = HW + 2;
  localparam int VS = VW + 2;

  logic          started;
  logic [HW-1:0] s_hsa, s_hbp, s_hact, s_hline;
  logic [VW-1:0] s_vsa, s_vbp, s_vact, s_vfp;
  logic [3:0]    s_pol;
  logic [5:0]    s_lp;

  logic [HS-1:0] h1, h2, h3, hpos;
  logic [VS-1:0] v1, v2, v3, vtot;
  logic          run, bad, live, eol, eof;
  logic          hs_a, vs_a, de_a, lp_reg;

  assign run  = en & cfg_video_mode & cfg_burst;
  assign h1   = {2'b00, s_hsa};
  assign h2   = h1 + {2'b00, s_hbp};
  assign h3   = h2 + {2'b00, s_hact};
  assign v1   = {2'b00, s_vsa};
  assign v2   = v1 + {2'b00, s_vbp};
  assign v3   = v2 + {2'b00, s_vact};
  assign vtot = v3 + {2'b00, s_vfp};
  assign hpos = {2'b00, hcnt};

  assign bad  = ({2'b00, s_hline} <= h3) | (vtot == '0);
  assign live = started & ~bad;
  assign eol  = hcnt == s_hline - 1'b1;
  assign eof  = eol & (vcnt == vtot - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
      s_hsa   <= '0;
      s_hbp   <= '0;
      s_hact  <= '0;
      s_hline <= '0;
      s_vsa   <= '0;
      s_vbp   <= '0;
      s_vact  <= '0;
      s_vfp   <= '0;
      s_pol   <= '0;
      s_lp    <= '0;
    end else if (!run || !started || bad || eof) begin
      started <= run;
      hcnt    <= '0;
      vcnt    <= '0;
      s_hsa   <= hsa;
      s_hbp   <= hbp;
      s_hact  <= hact;
      s_hline <= hline;
      s_vsa   <= vsa;
      s_vbp   <= vbp;
      s_vact  <= vact;
      s_vfp   <= vfp;
      s_pol   <= {pol_pix_fall, pol_de_low, pol_vs_low, pol_hs_low};
      s_lp    <= {lp_cmd_en, lp_hfp_en, lp_vfp_en, lp_vact_en, lp_vbp_en, lp_vsa_en};
    end else begin
      hcnt <= eol ? '0 : hcnt + 1'b1;
      if (eol) vcnt <= vcnt + 1'b1;
    end
  end

  always_comb begin
    if (!live)          vregion = 2'd0;
    else if (vcnt < v1) vregion = 2'd0;
    else if (vcnt < v2) vregion = 2'd1;
    else if (vcnt < v3) vregion = 2'd2;
    else                vregion = 2'd3;

    if (!live)          hregion = 2'd0;
    else if (hpos < h1) hregion = 2'd0;
    else if (hpos < h2) hregion = 2'd1;
    else if (hpos < h3) hregion = 2'd2;
    else                hregion = 2'd3;

    case (vregion)
      2'd0:    lp_reg = s_lp[0];
      2'd1:    lp_reg = s_lp[1];
      2'd3:    lp_reg = s_lp[3];
      default: lp_reg = (hregion == 2'd3) ? s_lp[4] :
                        (hregion == 2'd2) ? 1'b0 : s_lp[2];
    endcase
  end

  assign hs_a        = live & (hregion == 2'd0);
  assign vs_a        = live & (vregion == 2'd0);
  assign de_a        = live & (vregion == 2'd2) & (hregion == 2'd2);
  assign hsync       = hs_a ^ s_pol[0];
  assign vsync       = vs_a ^ s_pol[1];
  assign de          = de_a ^ s_pol[2];
  assign pix_fall    = s_pol[3];
  assign lp_ok       = live & lp_reg;
  assign lp_cmd_ok   = lp_ok & s_lp[5];
  assign frame_start = live & (hcnt == '0) & (vcnt == '0);
  assign cfg_err     = started & bad;
endmodule

module vid_region_seq_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          started,
  input logic          cfg_err,
  input logic [HW-1:0] hcnt,
  input logic [VW+1:0] vcnt,
  input logic [1:0]    vregion,
  input logic [1:0]    hregion,
  input logic          frame_start,
  input logic          lp_ok,
  input logic          lp_cmd_ok,
  input logic          de,
  input logic [3:0]    s_pol
);
  a_r1_idle_counters: assert property (@(posedge clk) disable iff (rst)
    !started |-> (hcnt == '0 && vcnt == '0 && !frame_start && !lp_ok));

  a_r2_pixel_step: assert property (@(posedge clk) disable iff (rst)
    (started && !cfg_err && hcnt != '0) |-> hcnt == $past(hcnt) + 1'b1);

  a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
    (started && !cfg_err && hcnt != '0) |-> vcnt == $past(vcnt));

  a_r5_de_window: assert property (@(posedge clk) disable iff (rst)
    (de != s_pol[2]) |-> (vregion == 2'd2 && hregion == 2'd2));

  a_r7_no_lp_active: assert property (@(posedge clk) disable iff (rst)
    (vregion == 2'd2 && hregion == 2'd2) |-> !lp_ok);

  a_r8_cmd_needs_lp: assert property (@(posedge clk) disable iff (rst)
    lp_cmd_ok |-> lp_ok);

  a_r9_start_origin: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (hcnt == '0 && vcnt == '0 && !cfg_err));

  a_r11_err_frozen: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (hcnt == '0 && vcnt == '0 && !frame_start && !lp_ok));
endmodule

bind vid_region_seq vid_region_seq_chk #(.HW(HW), .VW(VW)) u_chk (.*);

// File: tb/vid_region_seq_tb.sv
module vid_region_seq_tb;
  localparam int HW = 8;
  localparam int VW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, cfg_video_mode = 1'b1, cfg_burst = 1'b1;
  logic [HW-1:0] hsa, hbp, hact, hline;
  logic [VW-1:0] vsa, vbp, vact, vfp;
  logic pol_hs_low, pol_vs_low, pol_de_low, pol_pix_fall;
  logic lp_vsa_en, lp_vbp_en, lp_vact_en, lp_vfp_en, lp_hfp_en, lp_cmd_en;
  logic hsync, vsync, de, pix_fall, lp_ok, lp_cmd_ok, frame_start, cfg_err;
  logic [HW-1:0] hcnt;
  logic [VW+1:0] vcnt;
  logic [1:0] vregion, hregion;

  int nchk = 0, nerr = 0;
  int e_hsa, e_hbp, e_hact, e_hline, e_vsa, e_vbp, e_vact, e_vfp;
  int e_pol, e_lp, eh, ev;

  always #5 clk = ~clk;

  vid_region_seq #(.HW(HW), .VW(VW)) u_dut (.*);

  task automatic chk(string r, int a, int e);
    nchk++;
    if (a != e) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", r, a, e, $time);
    end
  endtask

  task automatic set_cfg(int a, int b, int c, int l, int s, int p, int q, int f);
    hsa = HW'(a); hbp = HW'(b); hact = HW'(c); hline = HW'(l);
    vsa = VW'(s); vbp = VW'(p); vact = VW'(q); vfp = VW'(f);
  endtask

  task automatic set_bits(int pol, int lp);
    {pol_pix_fall, pol_de_low, pol_vs_low, pol_hs_low} = 4'(pol);
    {lp_cmd_en, lp_hfp_en, lp_vfp_en, lp_vact_en, lp_vbp_en, lp_vsa_en} = 6'(lp);
  endtask

  task automatic latch_model();
    e_hsa = hsa; e_hbp = hbp; e_hact = hact; e_hline = hline;
    e_vsa = vsa; e_vbp = vbp; e_vact = vact; e_vfp = vfp;
    e_pol = {pol_pix_fall, pol_de_low, pol_vs_low, pol_hs_low};
    e_lp  = {lp_cmd_en, lp_hfp_en, lp_vfp_en, lp_vact_en, lp_vbp_en, lp_vsa_en};
    eh = 0; ev = 0;
  endtask

  task automatic check_state();
    int vr, hr, lp;
    if (ev < e_vsa) vr = 0;
    else if (ev < e_vsa + e_vbp) vr = 1;
    else if (ev < e_vsa + e_vbp + e_vact) vr = 2;
    else vr = 3;
    if (eh < e_hsa) hr = 0;
    else if (eh < e_hsa + e_hbp) hr = 1;
    else if (eh < e_hsa + e_hbp + e_hact) hr = 2;
    else hr = 3;
    case (vr)
      0: lp = e_lp & 1;
      1: lp = (e_lp >> 1) & 1;
      3: lp = (e_lp >> 3) & 1;
      default: lp = (hr == 3) ? (e_lp >> 4) & 1 : (hr == 2) ? 0 : (e_lp >> 2) & 1;
    endcase
    chk("R2 hcnt", int'(hcnt), eh);
    chk("R2 vcnt", int'(vcnt), ev);
    chk("R3 vregion", int'(vregion), vr);
    chk("R4 hregion", int'(hregion), hr);
    chk("R5/R6 hsync", int'(hsync), int'(hr == 0) ^ (e_pol & 1));
    chk("R5/R6 vsync", int'(vsync), int'(vr == 0) ^ ((e_pol >> 1) & 1));
    chk("R5/R6 de", int'(de), int'(vr == 2 && hr == 2) ^ ((e_pol >> 2) & 1));
    chk("R6 pix_fall", int'(pix_fall), (e_pol >> 3) & 1);
    chk("R7 lp_ok", int'(lp_ok), lp);
    chk("R8 lp_cmd_ok", int'(lp_cmd_ok), lp & ((e_lp >> 5) & 1));
    chk("R9 frame_start", int'(frame_start), int'(eh == 0 && ev == 0));
    chk("R11 cfg_err", int'(cfg_err), 0);
  endtask

  task automatic advance_model();
    eh++;
    if (eh == e_hline) begin
      eh = 0; ev++;
      if (ev == e_vsa + e_vbp + e_vact + e_vfp) latch_model();
    end
  endtask

  task automatic restart();
    en = 1'b0;
    @(posedge clk); #1;
    en = 1'b1;
    latch_model();
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      check_state();
      advance_model();
    end
  endtask

  task automatic check_idle(string r);
    chk({r, " idle hcnt"}, int'(hcnt), 0);
    chk({r, " idle vcnt"}, int'(vcnt), 0);
    chk({r, " idle frame_start"}, int'(frame_start), 0);
    chk({r, " idle lp_ok"}, int'(lp_ok), 0);
    chk({r, " idle hsync level"}, int'(hsync), int'(pol_hs_low));
    chk({r, " idle vsync level"}, int'(vsync), int'(pol_vs_low));
    chk({r, " idle de level"}, int'(de), int'(pol_de_low));
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    set_cfg(2, 3, 4, 12, 1, 2, 3, 2);
    set_bits(0, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset hcnt", int'(hcnt), 0);
    chk("R1 reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;

    // R1: each run condition missing keeps the block idle
    set_bits(7, 63);
    en = 1'b1; cfg_burst = 1'b0;
    repeat (3) @(posedge clk);
    #1; check_idle("R1 no burst");
    cfg_burst = 1'b1; cfg_video_mode = 1'b0;
    repeat (3) @(posedge clk);
    #1; check_idle("R1 command mode");
    cfg_video_mode = 1'b1; en = 1'b0;
    repeat (3) @(posedge clk);
    #1; check_idle("R1 disabled");
    chk("R11 idle cfg_err", int'(cfg_err), 0);

    // R5 R6 R7 R8: all low-power patterns with varied polarity
    for (int k = 0; k < 64; k++) begin
      set_bits((k ^ (k >> 2)) & 15, k);
      restart();
      run_cycles(96);
    end

    // R2 R3 R4: degenerate and larger rasters
    set_bits(5, 45);
    set_cfg(0, 0, 1, 2, 0, 0, 1, 0); restart(); run_cycles(6);
    set_cfg(0, 0, 0, 1, 0, 0, 0, 1); restart(); run_cycles(4);
    set_cfg(3, 1, 5, 10, 2, 1, 4, 3); restart(); run_cycles(200);
    set_cfg(1, 0, 6, 8, 0, 2, 2, 0); restart(); run_cycles(70);

    // R10: reprogram mid-frame, applies at next frame
    set_bits(0, 21);
    set_cfg(2, 3, 4, 12, 1, 2, 3, 2); restart();
    run_cycles(40);
    set_cfg(1, 1, 3, 7, 2, 1, 2, 1);
    set_bits(11, 42);
    run_cycles(56 + 91);

    // R11: invalid configurations
    set_cfg(2, 3, 4, 9, 1, 2, 3, 2); restart();
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R11 zero front porch cfg_err", int'(cfg_err), 1);
      chk("R11 zero front porch hcnt", int'(hcnt), 0);
      chk("R11 zero front porch frame_start", int'(frame_start), 0);
      chk("R11 zero front porch hsync idle", int'(hsync), int'(pol_hs_low));
    end
    set_cfg(2, 3, 4, 5, 1, 2, 3, 2);
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R11 negative front porch cfg_err", int'(cfg_err), 1);
    set_cfg(2, 3, 4, 12, 0, 0, 0, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R11 zero lines cfg_err", int'(cfg_err), 1);
    chk("R11 zero lines lp_ok", int'(lp_ok), 0);
    set_cfg(2, 3, 4, 10, 1, 1, 2, 1);
    latch_model();
    run_cycles(60);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule